// File: doc/BRIEF.md
# Multicast Crossbar Fabric Scheduler

This block is a cycle-based N x N switching fabric together with its connection scheduler (N = 13 by default, 32-bit paths). In every fabric cycle each input port may present one request: a bitmap naming the output ports it wants, plus one data word. Every output runs its own round-robin arbiter over the inputs that name it. An input is accepted only when every output in its bitmap picked it in that cycle. The fabric then copies the accepted word to all of those outputs in a single transfer, so the word is not replicated upstream.

Input queues sit in front of the fabric and output queues behind it. The input side uses a valid/ready handshake. Ready is a combinational answer in the same cycle as valid. A request that is not accepted must be held unchanged by its source. An accepted word leaves on the selected outputs one clock later, each marked by an output-valid flag.

When a multicast request loses the all-or-nothing test, the outputs that picked it stay idle. To stop two multicast requests from blocking each other for ever, any output whose pick was rejected points itself at the lowest-numbered rejected input that asks for it. That input then wins that output on the next cycle.

Top module: `mcast_xbar_fabric`

## Requirements
- R1: A synchronous active-high reset clears every out_valid bit on the next clock and sets every output's round-robin pointer to input 0, so the first contention after reset goes to the lowest-numbered requester.
- R2: Each output serves at most one input per cycle. Among the inputs whose bitmap names it, an output picks the first one found by scanning upward from its pointer and wrapping from N-1 to 0.
- R3: After an output carries an accepted transfer from input w, its pointer becomes w+1 (wrapping to 0 after N-1). Input w therefore wins that output again next cycle only if it is the sole requester.
- R4: An output that has no requester in a cycle keeps its pointer unchanged.
- R5: A request is accepted (in_ready high) only if every output named in its bitmap picked that input in the same cycle. Otherwise it is refused as a whole and no output carries it.
- R6: Bit o of input i's bitmap is in_dest[i*N+o], and its word is in_data[i*32 +: 32]. One clock after acceptance, every output o named in the bitmap shows out_valid[o] high and out_data[o*32 +: 32] equal to the word.
- R7: in_ready for an input is low whenever its in_valid is low, whatever its bitmap holds.
- R8: If an output's pick is refused, its pointer moves to the lowest-numbered refused pick of that cycle, provided that input requests this output. Otherwise the pointer is held.
- R9: A valid request with an all-zero bitmap is accepted at once and drives no output.
- R10: An output that carries no accepted transfer in a cycle shows out_valid low on the next clock. This includes an output whose pick was refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_PORTS | Request present, one bit per input |
| in_dest | input | N_PORTS*N_PORTS | Destination bitmaps; bits [i*N +: N] belong to input i |
| in_data | input | N_PORTS*DATA_W | Data words; bits [i*DATA_W +: DATA_W] belong to input i |
| in_ready | output | N_PORTS | Request accepted this cycle, one bit per input |
| out_valid | output | N_PORTS | Output carries a word this cycle |
| out_data | output | N_PORTS*DATA_W | Output words; bits [o*DATA_W +: DATA_W] belong to output o |

## Verification
in_ready is due in the same cycle that the request is presented. The bench drives requests just after a falling edge and samples in_ready a quarter period later, before the rising edge that commits the transfer. out_valid and out_data are due exactly one rising edge after acceptance, so the bench reads them at the following falling edge and compares them with the prediction made for that one transfer. Pointer effects (R3, R4, R8) only become visible one or two cycles later, through which input wins, so each scenario checks the in_ready pattern of the specific later cycle where the pointer change shows.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;
  localparam int MAX_PORTS = 64;

  // next index after v in a ring of n
  function automatic int wrap_inc(int v, int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // first set bit found scanning upward from start with wraparound, -1 if none
  function automatic int first_from(logic [MAX_PORTS-1:0] req, int start, int n);
    int found;
    int idx;
    found = -1;
    for (int k = 0; k < n; k++) begin
      idx = start + k;
      if (idx >= n) idx = idx - n;
      if (found < 0 && req[idx]) found = idx;
    end
    return found;
  endfunction

  // lowest set bit, -1 if none
  function automatic int lowest_set(logic [MAX_PORTS-1:0] v, int n);
    int found;
    found = -1;
    for (int k = n - 1; k >= 0; k--) begin
      if (v[k]) found = k;
    end
    return found;
  endfunction
endpackage

// File: rtl/xbar_out_arb.sv
`timescale 1ns/1ps
module xbar_out_arb
  import xbar_pkg::*;
#(
  parameter int N_PORTS = 13,
  localparam int PTR_W = $clog2(N_PORTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_PORTS-1:0] req,
  input  logic               win_ok,
  input  logic               rescue_vld,
  input  logic [PTR_W-1:0]   rescue_idx,
  output logic               win_vld,
  output logic [PTR_W-1:0]   win_idx,
  output logic [N_PORTS-1:0] grant
);
  logic [PTR_W-1:0] ptr_q;
  int pick;

  always_comb begin
    pick    = first_from(MAX_PORTS'(req), int'(ptr_q), N_PORTS);
    win_vld = (pick >= 0);
    win_idx = win_vld ? PTR_W'(pick) : '0;
    grant   = win_vld ? (N_PORTS'(1) << win_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (win_vld && win_ok) begin
      ptr_q <= PTR_W'(wrap_inc(int'(win_idx), N_PORTS));
    end else if (win_vld && rescue_vld && req[rescue_idx]) begin
      ptr_q <= rescue_idx;
    end
  end

  // R2: the pick is always a requester
  p_pick_is_requester_r2: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> req[win_idx]);

  // R3: a served input cannot win again next cycle unless it is alone
  p_rr_moves_on_r3: assert property (@(posedge clk) disable iff (rst)
    (win_vld && win_ok) |=> (!win_vld || win_idx != $past(win_idx) || $countones(req) == 1));

  // R4: idle output keeps its pointer
  p_idle_holds_ptr_r4: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> $stable(ptr_q));
endmodule

// File: rtl/xbar_accept.sv
`timescale 1ns/1ps
module xbar_accept
  import xbar_pkg::*;
#(
  parameter int N_PORTS = 13,
  localparam int PTR_W = $clog2(N_PORTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_PORTS-1:0]         in_valid,
  input  logic [N_PORTS*N_PORTS-1:0] in_dest,
  input  logic [N_PORTS*N_PORTS-1:0] grant_flat,
  output logic [N_PORTS-1:0]         in_ready,
  output logic [N_PORTS-1:0]         win_ok,
  output logic                       rescue_vld,
  output logic [PTR_W-1:0]           rescue_idx
);
  // picked_by[i][o]: output o picked input i
  logic [N_PORTS-1:0][N_PORTS-1:0] picked_by;
  logic [N_PORTS-1:0] refused;
  int low;

  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_in
    for (genvar go = 0; go < N_PORTS; go++) begin : g_col
      assign picked_by[gi][go] = grant_flat[go*N_PORTS + gi];
    end
    assign in_ready[gi] = in_valid[gi] &&
                          ((in_dest[gi*N_PORTS +: N_PORTS] & ~picked_by[gi]) == '0);
    assign refused[gi]  = (|picked_by[gi]) && !in_ready[gi];
  end

  for (genvar go = 0; go < N_PORTS; go++) begin : g_out
    assign win_ok[go] = |(grant_flat[go*N_PORTS +: N_PORTS] & in_ready);
  end

  always_comb begin
    low        = lowest_set(MAX_PORTS'(refused), N_PORTS);
    rescue_vld = (low >= 0);
    rescue_idx = rescue_vld ? PTR_W'(low) : '0;
  end

  // R8: the rescue target is an input that was just refused
  p_rescue_is_refused_r8: assert property (@(posedge clk) disable iff (rst)
    rescue_vld |-> (in_valid[rescue_idx] && !in_ready[rescue_idx]));
endmodule

// File: rtl/xbar_out_stage.sv
`timescale 1ns/1ps
module xbar_out_stage #(
  parameter int N_PORTS = 13,
  parameter int DATA_W  = 32,
  localparam int PTR_W = $clog2(N_PORTS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_PORTS-1:0]        win_ok,
  input  logic [N_PORTS*PTR_W-1:0]  sel_flat,
  input  logic [N_PORTS*DATA_W-1:0] in_data,
  output logic [N_PORTS-1:0]        out_valid,
  output logic [N_PORTS*DATA_W-1:0] out_data
);
  for (genvar go = 0; go < N_PORTS; go++) begin : g_lane
    logic [PTR_W-1:0] sel;
    assign sel = sel_flat[go*PTR_W +: PTR_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid[go]                   <= 1'b0;
        out_data[go*DATA_W +: DATA_W]   <= '0;
      end else begin
        out_valid[go] <= win_ok[go];
        if (win_ok[go]) begin
          out_data[go*DATA_W +: DATA_W] <= in_data[int'(sel)*DATA_W +: DATA_W];
        end
      end
    end
  end
endmodule

// File: rtl/mcast_xbar_fabric.sv
`timescale 1ns/1ps
module mcast_xbar_fabric #(
  parameter int N_PORTS = 13,
  parameter int DATA_W  = 32,
  localparam int PTR_W = $clog2(N_PORTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_PORTS-1:0]         in_valid,
  input  logic [N_PORTS*N_PORTS-1:0] in_dest,
  input  logic [N_PORTS*DATA_W-1:0]  in_data,
  output logic [N_PORTS-1:0]         in_ready,
  output logic [N_PORTS-1:0]         out_valid,
  output logic [N_PORTS*DATA_W-1:0]  out_data
);
  // named internal events
  logic [N_PORTS*N_PORTS-1:0] grant_flat;   // [o*N + i]
  logic [N_PORTS*PTR_W-1:0]   sel_flat;
  logic [N_PORTS-1:0]         win_vld;
  logic [N_PORTS-1:0]         win_ok;
  logic                       rescue_vld;
  logic [PTR_W-1:0]           rescue_idx;
  logic [N_PORTS-1:0][N_PORTS-1:0] dest_col;  // [o][i]
  logic [N_PORTS-1:0]         accepted;

  assign accepted = in_valid & in_ready;

  for (genvar go = 0; go < N_PORTS; go++) begin : g_arb
    for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_req
      assign dest_col[go][gi] = in_dest[gi*N_PORTS + go];
    end

    xbar_out_arb #(.N_PORTS(N_PORTS)) u_arb (
      .clk        (clk),
      .rst        (rst),
      .req        (in_valid & dest_col[go]),
      .win_ok     (win_ok[go]),
      .rescue_vld (rescue_vld),
      .rescue_idx (rescue_idx),
      .win_vld    (win_vld[go]),
      .win_idx    (sel_flat[go*PTR_W +: PTR_W]),
      .grant      (grant_flat[go*N_PORTS +: N_PORTS])
    );
  end

  xbar_accept #(.N_PORTS(N_PORTS)) u_accept (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_dest    (in_dest),
    .grant_flat (grant_flat),
    .in_ready   (in_ready),
    .win_ok     (win_ok),
    .rescue_vld (rescue_vld),
    .rescue_idx (rescue_idx)
  );

  xbar_out_stage #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .win_ok    (win_ok),
    .sel_flat  (sel_flat),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // R1: reset empties every output
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (out_valid == '0));

  for (genvar go = 0; go < N_PORTS; go++) begin : g_chk_out
    // R2: never two accepted inputs on one output
    p_one_driver_r2: assert property (@(posedge clk) disable iff (rst)
      $countones(accepted & dest_col[go]) <= 1);
    // R10: output not targeted by an accepted input stays quiet
    p_quiet_output_r10: assert property (@(posedge clk) disable iff (rst)
      ((accepted & dest_col[go]) == '0) |=> !out_valid[go]);
  end

  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_chk_in
    // R5: an accepted bitmap is delivered in full
    p_full_copy_r5: assert property (@(posedge clk) disable iff (rst)
      accepted[gi] |=> ((out_valid & $past(in_dest[gi*N_PORTS +: N_PORTS]))
                        == $past(in_dest[gi*N_PORTS +: N_PORTS])));
    // R7: no ready without valid
    p_ready_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
      !in_valid[gi] |-> !in_ready[gi]);
    // R9: empty bitmap goes through at once
    p_empty_accepts_r9: assert property (@(posedge clk) disable iff (rst)
      (in_valid[gi] && in_dest[gi*N_PORTS +: N_PORTS] == '0) |-> in_ready[gi]);
    for (genvar go = 0; go < N_PORTS; go++) begin : g_data
      // R6: word arrives one clock later on each chosen output
      p_word_delivered_r6: assert property (@(posedge clk) disable iff (rst)
        (accepted[gi] && in_dest[gi*N_PORTS + go])
          |=> (out_data[go*DATA_W +: DATA_W] == $past(in_data[gi*DATA_W +: DATA_W])));
    end
  end
endmodule

// File: tb/mcast_xbar_fabric_test.sv
`timescale 1ns/1ps
module mcast_xbar_fabric_test;
  localparam int NP = 13;
  localparam int DW = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NP-1:0]     in_valid = '0;
  logic [NP*NP-1:0]  in_dest = '0;
  logic [NP*DW-1:0]  in_data = '0;
  logic [NP-1:0]     in_ready;
  logic [NP-1:0]     out_valid;
  logic [NP*DW-1:0]  out_data;

  always #10 clk = ~clk;

  mcast_xbar_fabric #(.N_PORTS(NP), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
  );

  int vectors = 0;
  int miscompares = 0;

  // pending requests and the bench's own view of the pointers
  logic          rv [NP];
  logic [NP-1:0] rd [NP];
  logic [DW-1:0] rw [NP];
  int            mptr [NP];
  logic [NP-1:0] exp_ready, exp_ov, last_ready, last_ov;
  logic [DW-1:0] exp_od [NP];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_reqs();
    for (int i = 0; i < NP; i++) begin
      rv[i] = 1'b0; rd[i] = '0; rw[i] = '0;
    end
  endtask

  task automatic do_reset();
    clear_reqs();
    in_valid = '0; in_dest = '0; in_data = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int o = 0; o < NP; o++) mptr[o] = 0;
  endtask

  // prediction of one fabric cycle from the requirements
  task automatic predict();
    int win [NP];
    int refused_low;
    for (int o = 0; o < NP; o++) begin
      win[o] = -1;
      for (int k = 0; k < NP; k++) begin
        int idx;
        idx = (mptr[o] + k) % NP;
        if (win[o] < 0 && rv[idx] && rd[idx][o]) win[o] = idx;
      end
    end
    for (int i = 0; i < NP; i++) begin
      exp_ready[i] = rv[i];
      for (int o = 0; o < NP; o++)
        if (rv[i] && rd[i][o] && win[o] != i) exp_ready[i] = 1'b0;
    end
    refused_low = -1;
    for (int i = NP - 1; i >= 0; i--)
      for (int o = 0; o < NP; o++)
        if (win[o] == i && !exp_ready[i]) refused_low = i;
    for (int o = 0; o < NP; o++) begin
      exp_ov[o] = (win[o] >= 0) && exp_ready[win[o]];
      exp_od[o] = exp_ov[o] ? rw[win[o]] : '0;
      if (exp_ov[o]) mptr[o] = (win[o] + 1) % NP;
      else if (win[o] >= 0 && refused_low >= 0 && rv[refused_low] && rd[refused_low][o])
        mptr[o] = refused_low;
    end
  endtask

  // one cycle: drive after a falling edge, ready before the rising edge,
  // outputs at the next falling edge
  task automatic step(input string tag);
    for (int i = 0; i < NP; i++) begin
      in_valid[i]          = rv[i];
      in_dest[i*NP +: NP]  = rd[i];
      in_data[i*DW +: DW]  = rw[i];
    end
    predict();
    #5;
    last_ready = in_ready;
    chk(in_ready == exp_ready, tag, "in_ready", 64'(in_ready), 64'(exp_ready));
    @(posedge clk);
    for (int i = 0; i < NP; i++) if (exp_ready[i]) rv[i] = 1'b0;
    @(negedge clk);
    last_ov = out_valid;
    chk(out_valid == exp_ov, tag, "out_valid", 64'(out_valid), 64'(exp_ov));
    for (int o = 0; o < NP; o++)
      if (exp_ov[o])
        chk(out_data[o*DW +: DW] == exp_od[o], tag, $sformatf("out_data[%0d]", o),
            64'(out_data[o*DW +: DW]), 64'(exp_od[o]));
  endtask

  task automatic req(input int i, input logic [NP-1:0] d);
    rv[i] = 1'b1; rd[i] = d; rw[i] = 32'hC0DE_0000 + 32'(i * 257) + 32'($urandom % 4096);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(out_valid == '0, "R1", "out_valid after reset", 64'(out_valid), 64'h0);
    for (int i = 0; i < NP; i++) req(i, NP'(1));
    step("R1");
    chk(last_ready == NP'(1), "R1", "first winner after reset", 64'(last_ready), 64'h1);
  endtask

  task automatic t_unicast_perm();
    do_reset();
    for (int i = 0; i < NP; i++) req(i, NP'(1) << ((i + 3) % NP));
    step("R6");
    chk(last_ready == {NP{1'b1}}, "R6", "permutation all accepted", 64'(last_ready), 64'(NP'('1)));
    chk(last_ov == {NP{1'b1}}, "R6", "permutation all outputs", 64'(last_ov), 64'(NP'('1)));
  endtask

  task automatic t_contention();
    do_reset();
    for (int i = 0; i < NP; i++) req(i, NP'(1) << 5);
    for (int k = 0; k < NP; k++) begin
      step("R2");
      chk(last_ready == (NP'(1) << k), "R3", "round-robin order", 64'(last_ready), 64'(NP'(1) << k));
    end
  endtask

  task automatic t_idle_hold();
    do_reset();
    req(3, NP'(1) << 2);
    step("R3");
    repeat (4) step("R4");
    req(1, NP'(1) << 2);
    req(6, NP'(1) << 2);
    step("R4");
    chk(last_ready == (NP'(1) << 6), "R4", "pointer held over idle", 64'(last_ready), 64'(NP'(1) << 6));
  endtask

  task automatic t_broadcast();
    do_reset();
    req(2, '1);
    step("R5");
    chk(last_ov == {NP{1'b1}}, "R5", "broadcast to all outputs", 64'(last_ov), 64'(NP'('1)));
  endtask

  task automatic t_all_or_none();
    do_reset();
    req(0, NP'(1) << 1);
    step("R3");
    req(0, (NP'(1) << 1) | (NP'(1) << 2));
    req(1, NP'(1) << 1);
    step("R5");
    chk(last_ready == NP'(2), "R5", "multicast refused as a whole", 64'(last_ready), 64'h2);
    chk(last_ov == (NP'(1) << 1), "R10", "refused pick leaves output quiet", 64'(last_ov), 64'(NP'(1) << 1));
    step("R5");
    chk(last_ready == NP'(1), "R5", "held multicast then served", 64'(last_ready), 64'h1);
    chk(last_ov == NP'(6), "R6", "multicast copies", 64'(last_ov), 64'h6);
  endtask

  task automatic t_rescue();
    do_reset();
    req(0, NP'(1) << 4);
    step("R3");
    req(0, (NP'(1) << 3) | (NP'(1) << 4));
    req(1, (NP'(1) << 3) | (NP'(1) << 4));
    step("R8");
    chk(last_ready == '0, "R8", "crossed picks refuse both", 64'(last_ready), 64'h0);
    chk(last_ov == '0, "R10", "no output after crossed picks", 64'(last_ov), 64'h0);
    step("R8");
    chk(last_ready == NP'(1), "R8", "rescue serves input 0", 64'(last_ready), 64'h1);
    step("R8");
    chk(last_ready == NP'(2), "R8", "then input 1", 64'(last_ready), 64'h2);
  endtask

  task automatic t_empty_bitmap();
    do_reset();
    req(7, '0);
    req(8, NP'(1));
    step("R9");
    chk(last_ready == ((NP'(1) << 7) | (NP'(1) << 8)), "R9", "empty bitmap accepted",
        64'(last_ready), 64'((NP'(1) << 7) | (NP'(1) << 8)));
    chk(last_ov == NP'(1), "R9", "empty bitmap drives nothing", 64'(last_ov), 64'h1);
  endtask

  task automatic t_no_valid();
    do_reset();
    for (int i = 0; i < NP; i++) begin rv[i] = 1'b0; rd[i] = '1; rw[i] = 32'(i); end
    step("R7");
    chk(last_ready == '0, "R7", "ready low without valid", 64'(last_ready), 64'h0);
    chk(last_ov == '0, "R7", "no output without valid", 64'(last_ov), 64'h0);
  endtask

  task automatic t_mixed_traffic();
    do_reset();
    for (int c = 0; c < 400; c++) begin
      for (int i = 0; i < NP; i++)
        if (!rv[i] && ($urandom % 3 == 0))
          req(i, NP'($urandom & $urandom & $urandom));
      step("R5");
    end
    for (int c = 0; c < 60; c++) step("R2");
  endtask

  initial begin
    clear_reqs();
    for (int o = 0; o < NP; o++) begin mptr[o] = 0; exp_od[o] = '0; end
    t_reset_state();
    t_unicast_perm();
    t_contention();
    t_idle_hold();
    t_broadcast();
    t_all_or_none();
    t_rescue();
    t_empty_bitmap();
    t_no_valid();
    t_mixed_traffic();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog run did not finish actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule